// File: doc/BRIEF.md
# Hit Frame Validator

This block receives frames on a hit channel, one 32-bit word per accepted beat, and checks each one against a fixed layout. A frame starts with a header and ends with a trailer, and a counted list of hit words sits between them. Its length and tags must be correct, and the crossing number in its header must match the crossing number of the matching reference frame. Reference crossing numbers are pushed into a small FIFO. One entry is consumed by every hit frame. When a check fails, a sticky error flag is set, and the block stops taking words on both inputs until reset.

Every accepted word is passed on, one cycle later, on a registered output stream. Two validator instances fed from different channels can then watch each other. When comparison is enabled, each unit compares its own output stream with its peer's stream, and any difference between them is flagged. The words of the most recent frame are kept in a 256-word capture buffer that can be read at any time through an address input.

Top module: `hit_frame_validator`

## Requirements
- R1: After reset, all error flags, `halted` and `outValid` are 0, `refReady` is 1, and `hitReady` is 0 because the reference FIFO is empty.
- R2: The reference FIFO holds 4 crossing numbers. `refReady` is low while it is full. A header word is accepted only while the FIFO is non-empty, and each accepted header pops exactly one entry.
- R3: A word that is accepted (`hitValid` and `hitReady` both high) appears on `outData` with `outValid` high in the next cycle. `outValid` is low in cycles after which no word was accepted.
- R4: The header's hit count is header bits [7:0]. If the number of words in a frame, header and trailer included, is not hit count + 2, `lenErr` is set in the cycle after the word with `hitLast` is accepted.
- R5: `fmtErr` is set in the cycle after the last word of a frame is accepted if any of these holds: header bits [31:28] are not 4'b1100; trailer bits [31:28] are not 4'b1111; header bits [19:8] differ from the crossing number popped for that frame.
- R6: While `cmpEnable` is high, a cycle in which `outValid` differs from `peerValid`, or in which both are high and `outData` differs from `peerData`, sets `cmpErr` in the next cycle. While `cmpEnable` is low, such a difference has no effect.
- R7: The error flags stay set until reset. While any of them is set, `halted` is high, and `hitReady` and `refReady` are both low.
- R8: Word k of the most recent frame (the header is k = 0) can be read on `bufData` at `bufAddr` k, for k below 256. Words with k of 256 or more are not stored. A new frame overwrites the buffer from address 0, and addresses past its end keep their older contents.
- R9: A frame of a single word (a header with `hitLast` high) counts as both header and trailer, so it sets both `lenErr` and `fmtErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refValid | input | 1 | Reference crossing number offered |
| refXing | input | 12 | Reference crossing number |
| refReady | output | 1 | Reference FIFO can take an entry |
| hitValid | input | 1 | Hit channel word offered |
| hitData | input | 32 | Hit channel word |
| hitLast | input | 1 | Offered word is the last word of its frame |
| hitReady | output | 1 | Hit word will be accepted this cycle |
| outValid | output | 1 | Registered copy of the accept strobe |
| outData | output | 32 | Last accepted word |
| cmpEnable | input | 1 | Enables comparison against the peer unit |
| peerValid | input | 1 | Peer unit's output valid |
| peerData | input | 32 | Peer unit's output word |
| lenErr | output | 1 | Sticky frame length error |
| fmtErr | output | 1 | Sticky tag or crossing error |
| cmpErr | output | 1 | Sticky peer comparison error |
| halted | output | 1 | Any error flag is set |
| bufAddr | input | 8 | Capture buffer read address |
| bufData | output | 32 | Capture buffer word at `bufAddr` |

## Verification
The assertions assume that `hitLast` is only meaningful while `hitValid` is high, and that `peerValid` and `peerData` come from a registered stream with the same timing as this unit's own output. The bench drives every input half a cycle away from the active edge. By default it feeds the peer inputs with the model's expected output, so the two streams match. It breaks that match for a single cycle only in the comparison tests. It also pushes reference crossing numbers before or during each frame, so that every popped entry has a defined value.

// File: rtl/hitval_pkg.sv
package hitval_pkg;
  localparam int WORD_W = 32;
  localparam logic [3:0] TAG_HEADER  = 4'b1100;
  localparam logic [3:0] TAG_TRAILER = 4'b1111;
  localparam int TAG_LSB   = 28;
  localparam int XING_LSB  = 8;
  localparam int COUNT_LSB = 0;

  typedef struct packed {
    logic accept;
    logic pop;
    logic frameEnd;
    logic lenBad;
    logic fmtBad;
    logic wrEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/hitval_ctrl.sv
module hitval_ctrl
  import hitval_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int XING_W    = 12,
  parameter int CNT_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         hitValid,
  input  logic                         hitLast,
  input  logic [3:0]                   tag,
  input  logic [XING_W-1:0]            xing,
  input  logic [CNT_W-1:0]             count,
  input  logic                         refEmpty,
  input  logic [XING_W-1:0]            refHead,
  input  logic                         halted,
  output logic                         hitReady,
  output ctrlStrobes_t                 strb,
  output logic [$clog2(BUF_DEPTH)-1:0] wrAddr
);
  localparam int AW    = $clog2(BUF_DEPTH);
  localparam int LEN_W = CNT_W + 2;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic             inFrame;
  logic [LEN_W-1:0] wordCnt;
  logic [LEN_W-1:0] expLen;
  logic             hdrOk;

  logic             isHeader;
  logic             accept;
  logic [LEN_W-1:0] nextCnt;
  logic [LEN_W-1:0] curLen;
  logic [LEN_W-1:0] curExp;
  logic             curHdrOk;
  logic [LEN_W-1:0] wordIdx;

  always_comb begin
    isHeader = !inFrame;
    hitReady = !halted && (inFrame || !refEmpty);
    accept   = hitValid && hitReady;
    nextCnt  = (wordCnt == LEN_MAX) ? wordCnt : wordCnt + 1'b1;
    curLen   = isHeader ? LEN_W'(1) : nextCnt;
    curExp   = isHeader ? LEN_W'(count) + LEN_W'(2) : expLen;
    curHdrOk = isHeader ? ((tag == TAG_HEADER) && (xing == refHead)) : hdrOk;
    wordIdx  = isHeader ? '0 : wordCnt;

    strb.accept   = accept;
    strb.pop      = accept && isHeader;
    strb.frameEnd = accept && hitLast;
    strb.lenBad   = (curLen != curExp);
    strb.fmtBad   = !curHdrOk || (tag != TAG_TRAILER);
    strb.wrEn     = accept && (wordIdx < LEN_W'(BUF_DEPTH));
    wrAddr        = wordIdx[AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      wordCnt <= '0;
      expLen  <= '0;
      hdrOk   <= 1'b0;
    end else if (accept) begin
      inFrame <= !hitLast;
      if (isHeader) begin
        wordCnt <= LEN_W'(1);
        expLen  <= curExp;
        hdrOk   <= curHdrOk;
      end else begin
        wordCnt <= nextCnt;
      end
    end
  end

  // R7: a halted unit never offers to take a hit word
  a_r7_halt_blocks_hit: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !hitReady);

  // R2: a header can only be taken while a reference entry is waiting
  a_r2_header_has_ref: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !refEmpty);

  // R8: within a frame the write address climbs by one per accepted word
  a_r8_addr_steps: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !hitLast) |=> (!strb.wrEn || wrAddr == $past(wrAddr) + 1'b1));
endmodule

// File: rtl/hitval_datapath.sv
module hitval_datapath
  import hitval_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int REF_DEPTH = 4,
  parameter int XING_W    = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 strb,
  input  logic [$clog2(BUF_DEPTH)-1:0] wrAddr,
  input  logic [WORD_W-1:0]            hitData,
  input  logic                         refValid,
  input  logic [XING_W-1:0]            refXing,
  input  logic                         cmpEnable,
  input  logic                         peerValid,
  input  logic [WORD_W-1:0]            peerData,
  input  logic [$clog2(BUF_DEPTH)-1:0] bufAddr,
  output logic                         refReady,
  output logic                         refEmpty,
  output logic [XING_W-1:0]            refHead,
  output logic                         outValid,
  output logic [WORD_W-1:0]            outData,
  output logic                         lenErr,
  output logic                         fmtErr,
  output logic                         cmpErr,
  output logic                         halted,
  output logic [WORD_W-1:0]            bufData
);
  localparam int PW = (REF_DEPTH > 1) ? $clog2(REF_DEPTH) : 1;
  localparam int CW = $clog2(REF_DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(REF_DEPTH - 1);

  logic [XING_W-1:0] refMem [REF_DEPTH];
  logic [PW-1:0]     rdPtr, wrPtr;
  logic [CW-1:0]     refCount;
  logic              push;
  logic              cmpMiss;
  logic [WORD_W-1:0] capBuf [BUF_DEPTH];

  always_comb begin
    halted   = lenErr || fmtErr || cmpErr;
    refEmpty = (refCount == '0);
    refReady = !halted && (refCount != CW'(REF_DEPTH));
    push     = refValid && refReady;
    refHead  = refMem[rdPtr];
    cmpMiss  = cmpEnable && ((outValid != peerValid) ||
                             (outValid && (outData != peerData)));
    bufData  = capBuf[bufAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      refCount <= '0;
    end else begin
      if (push)     wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (strb.pop) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      if (push && !strb.pop)      refCount <= refCount + 1'b1;
      else if (!push && strb.pop) refCount <= refCount - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) refMem[wrPtr] <= refXing;
    if (strb.wrEn) capBuf[wrAddr] <= hitData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      lenErr   <= 1'b0;
      fmtErr   <= 1'b0;
      cmpErr   <= 1'b0;
    end else begin
      outValid <= strb.accept;
      if (strb.accept) outData <= hitData;
      if (strb.frameEnd && strb.lenBad) lenErr <= 1'b1;
      if (strb.frameEnd && strb.fmtBad) fmtErr <= 1'b1;
      if (cmpMiss) cmpErr <= 1'b1;
    end
  end

  // R2: occupancy never exceeds the FIFO depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    refCount <= CW'(REF_DEPTH));

  // R3: an accepted word is echoed one cycle later
  a_r3_echo: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> (outValid && outData == $past(hitData)));

  // R7: flags are sticky
  a_r7_len_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |=> lenErr);
  a_r7_fmt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fmtErr |=> fmtErr);
  a_r7_halt_blocks_ref: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !refReady);

  // R6: the comparison flag only rises when comparison was enabled
  a_r6_cmp_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpErr) |-> $past(cmpEnable));

  // R4: a length flag only rises after a frame has ended
  a_r4_len_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lenErr) |-> $past(strb.frameEnd));
endmodule

// File: rtl/hit_frame_validator.sv
module hit_frame_validator
  import hitval_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int REF_DEPTH = 4,
  parameter int XING_W    = 12,
  parameter int CNT_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         refValid,
  input  logic [XING_W-1:0]            refXing,
  output logic                         refReady,
  input  logic                         hitValid,
  input  logic [WORD_W-1:0]            hitData,
  input  logic                         hitLast,
  output logic                         hitReady,
  output logic                         outValid,
  output logic [WORD_W-1:0]            outData,
  input  logic                         cmpEnable,
  input  logic                         peerValid,
  input  logic [WORD_W-1:0]            peerData,
  output logic                         lenErr,
  output logic                         fmtErr,
  output logic                         cmpErr,
  output logic                         halted,
  input  logic [$clog2(BUF_DEPTH)-1:0] bufAddr,
  output logic [WORD_W-1:0]            bufData
);
  ctrlStrobes_t                 strb;
  logic [$clog2(BUF_DEPTH)-1:0] wrAddr;
  logic                         refEmpty;
  logic [XING_W-1:0]            refHead;

  hitval_ctrl #(.BUF_DEPTH(BUF_DEPTH), .XING_W(XING_W), .CNT_W(CNT_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hitValid (hitValid),
    .hitLast  (hitLast),
    .tag      (hitData[TAG_LSB +: 4]),
    .xing     (hitData[XING_LSB +: XING_W]),
    .count    (hitData[COUNT_LSB +: CNT_W]),
    .refEmpty (refEmpty),
    .refHead  (refHead),
    .halted   (halted),
    .hitReady (hitReady),
    .strb     (strb),
    .wrAddr   (wrAddr)
  );

  hitval_datapath #(.BUF_DEPTH(BUF_DEPTH), .REF_DEPTH(REF_DEPTH), .XING_W(XING_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrAddr    (wrAddr),
    .hitData   (hitData),
    .refValid  (refValid),
    .refXing   (refXing),
    .cmpEnable (cmpEnable),
    .peerValid (peerValid),
    .peerData  (peerData),
    .bufAddr   (bufAddr),
    .refReady  (refReady),
    .refEmpty  (refEmpty),
    .refHead   (refHead),
    .outValid  (outValid),
    .outData   (outData),
    .lenErr    (lenErr),
    .fmtErr    (fmtErr),
    .cmpErr    (cmpErr),
    .halted    (halted),
    .bufData   (bufData)
  );
endmodule

// File: tb/test_hit_frame_validator.sv
`timescale 1ns/100ps
module test_hit_frame_validator;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refValid = 1'b0;
  logic [11:0] refXing = '0;
  logic refReady;
  logic hitValid = 1'b0;
  logic [31:0] hitData = '0;
  logic hitLast = 1'b0;
  logic hitReady;
  logic outValid;
  logic [31:0] outData;
  logic cmpEnable = 1'b0;
  logic peerValid = 1'b0;
  logic [31:0] peerData = '0;
  logic lenErr, fmtErr, cmpErr, halted;
  logic [7:0] bufAddr = '0;
  logic [31:0] bufData;

  always #2.5 clk = ~clk;

  hit_frame_validator i_hit_frame_validator (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refXing(refXing), .refReady(refReady),
    .hitValid(hitValid), .hitData(hitData), .hitLast(hitLast), .hitReady(hitReady),
    .outValid(outValid), .outData(outData), .cmpEnable(cmpEnable),
    .peerValid(peerValid), .peerData(peerData), .lenErr(lenErr), .fmtErr(fmtErr),
    .cmpErr(cmpErr), .halted(halted), .bufAddr(bufAddr), .bufData(bufData));

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit injectPeer = 0;

  // Reference model state
  int          mRefs[$];
  logic [31:0] mFrame[$];
  logic [31:0] mBuf[256];
  bit          mKnown[256];
  bit          mInFrame = 0;
  bit          mLen = 0, mFmt = 0, mCmp = 0, mOutV = 0;
  logic [31:0] mOutD = '0;
  int          mPopped = 0;

  function automatic bit mHalt();
    return mLen || mFmt || mCmp;
  endfunction
  function automatic bit mHitRdy();
    return !mHalt() && (mInFrame || mRefs.size() > 0);
  endfunction
  function automatic bit mRefRdy();
    return !mHalt() && (mRefs.size() < 4);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mRefs.delete(); mFrame.delete();
      mInFrame = 0; mLen = 0; mFmt = 0; mCmp = 0; mOutV = 0; mOutD = '0;
    end else begin
      bit hr, rr, miss, acc;
      hr = mHitRdy(); rr = mRefRdy();
      miss = cmpEnable && ((mOutV != peerValid) || (mOutV && mOutD != peerData));
      acc = hitValid && hr;
      if (acc) begin
        if (!mInFrame) begin
          mFrame.delete();
          mPopped = mRefs.pop_front();
        end
        mFrame.push_back(hitData);
        if (mFrame.size() <= 256) begin
          mBuf[mFrame.size()-1] = hitData;
          mKnown[mFrame.size()-1] = 1;
        end
        if (hitLast) begin
          if (mFrame.size() != int'(mFrame[0][7:0]) + 2) mLen = 1;
          if (mFrame[0][31:28] != 4'b1100 || int'(mFrame[0][19:8]) != mPopped ||
              hitData[31:28] != 4'b1111) mFmt = 1;
        end
        mInFrame = !hitLast;
        mOutD = hitData;
      end
      mOutV = acc;
      if (miss) mCmp = 1;
      if (refValid && rr) mRefs.push_back(int'(refXing));
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check("R2/R7", "hitReady", {31'b0, hitReady}, {31'b0, mHitRdy()});
      check("R2/R7", "refReady", {31'b0, refReady}, {31'b0, mRefRdy()});
      check("R3", "outValid", {31'b0, outValid}, {31'b0, mOutV});
      if (mOutV) check("R3", "outData", outData, mOutD);
      check("R4", "lenErr", {31'b0, lenErr}, {31'b0, mLen});
      check("R5", "fmtErr", {31'b0, fmtErr}, {31'b0, mFmt});
      check("R6", "cmpErr", {31'b0, cmpErr}, {31'b0, mCmp});
      check("R7", "halted", {31'b0, halted}, {31'b0, mHalt()});
      if (mKnown[bufAddr]) check("R8", "bufData", bufData, mBuf[bufAddr]);
    end
    #1;
    peerValid = mOutV ^ injectPeer;
    peerData  = mOutD;
  end

  task automatic doReset();
    @(negedge clk); #1 rstN = 0; hitValid = 0; refValid = 0;
    repeat (2) @(negedge clk);
    #1 rstN = 1;
  endtask

  task automatic pushRef(input int x);
    for (int t = 0; t < 40; t++) begin
      @(negedge clk); #1 refValid = 1; refXing = 12'(x);
      if (mRefRdy()) break;
    end
    @(negedge clk); #1 refValid = 0;
  endtask

  function automatic logic [31:0] hdr(input int xing, input int cnt);
    return {4'b1100, 8'h5A, 12'(xing), 8'(cnt)};
  endfunction

  // Sends nWords words: header, hits, trailer; gap adds idle cycles
  task automatic sendFrame(input logic [31:0] h, input int nWords,
                           input logic [3:0] trlTag, input int gap);
    for (int i = 0; i < nWords; i++) begin
      logic [31:0] w;
      w = (i == 0) ? h : (i == nWords-1) ? {trlTag, 28'(i * 3 + 7)} : {4'h3, 28'(i * 17 + h[7:0])};
      for (int t = 0; t < 60; t++) begin
        @(negedge clk); #1 hitValid = 1; hitData = w; hitLast = (i == nWords-1);
        if (mHitRdy()) break;
      end
      if (gap > 0 && i % 2 == 1) begin
        @(negedge clk); #1 hitValid = 0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk); #1 hitValid = 0; hitLast = 0;
  endtask

  task automatic readBuf(input int addr, input logic [31:0] exp, input string req);
    @(negedge clk); #1 bufAddr = 8'(addr);
    @(negedge clk); #0;
    check(req, "buffer readback", bufData, exp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mKnown[i] = 0;
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk); #0;
    check("R1", "lenErr", {31'b0, lenErr}, 32'd0);
    check("R1", "halted", {31'b0, halted}, 32'd0);
    check("R1", "outValid", {31'b0, outValid}, 32'd0);
    check("R1", "refReady", {31'b0, refReady}, 32'd1);
    check("R1", "hitReady", {31'b0, hitReady}, 32'd0);

    // R2: header waits while no reference is present
    #1 hitValid = 1; hitData = hdr(12'h101, 0); hitLast = 0;
    repeat (3) @(negedge clk);
    #0 check("R2", "header stalls on empty FIFO", {31'b0, hitReady}, 32'd0);
    #1 hitValid = 0;
    pushRef(12'h101); pushRef(12'h102); pushRef(12'h103); pushRef(12'h104);
    @(negedge clk); #0 check("R2", "refReady when full", {31'b0, refReady}, 32'd0);

    sendFrame(hdr(12'h101, 0), 2, 4'hF, 0);
    sendFrame(hdr(12'h102, 3), 5, 4'hF, 2);
    sendFrame(hdr(12'h103, 5), 7, 4'hF, 0);
    readBuf(0, hdr(12'h103, 5), "R8");
    readBuf(6, {4'hF, 28'(6 * 3 + 7)}, "R8");

    // R8: long frame keeps only the first 256 words
    sendFrame(hdr(12'h104, 255), 257, 4'hF, 0);
    readBuf(255, {4'h3, 28'(255 * 17 + 255)}, "R8");
    pushRef(12'h105);
    sendFrame(hdr(12'h105, 1), 3, 4'hF, 1);
    readBuf(3, {4'h3, 28'(3 * 17 + 255)}, "R8");
    check("R4", "no length error on good frames", {31'b0, lenErr}, 32'd0);

    // R6: mismatch ignored while compare disabled, flagged when enabled
    @(negedge clk); #1 injectPeer = 1;
    @(negedge clk); #1 injectPeer = 0;
    repeat (2) @(negedge clk);
    #0 check("R6", "no flag with compare off", {31'b0, cmpErr}, 32'd0);
    #1 cmpEnable = 1;
    pushRef(12'h106);
    sendFrame(hdr(12'h106, 2), 4, 4'hF, 0);
    check("R6", "matching peer stays clean", {31'b0, cmpErr}, 32'd0);
    @(negedge clk); #1 injectPeer = 1;
    @(negedge clk); #1 injectPeer = 0;
    @(negedge clk); #0 check("R6", "mismatch flagged", {31'b0, cmpErr}, 32'd1);
    #1 cmpEnable = 0; hitValid = 1; refValid = 1;
    @(negedge clk); #0 check("R7", "hitReady blocked", {31'b0, hitReady}, 32'd0);
    check("R7", "refReady blocked", {31'b0, refReady}, 32'd0);
    #1 hitValid = 0; refValid = 0;
    doReset();

    // R4: one word too many
    pushRef(12'h200);
    sendFrame(hdr(12'h200, 3), 6, 4'hF, 0);
    check("R4", "length flag", {31'b0, lenErr}, 32'd1);
    check("R4", "no format flag", {31'b0, fmtErr}, 32'd0);
    repeat (3) @(negedge clk);
    #0 check("R7", "length flag sticky", {31'b0, lenErr}, 32'd1);
    doReset();

    // R5: crossing mismatch
    pushRef(12'h300);
    sendFrame(hdr(12'h301, 1), 3, 4'hF, 0);
    check("R5", "crossing mismatch", {31'b0, fmtErr}, 32'd1);
    doReset();
    // R5: bad trailer tag
    pushRef(12'h310);
    sendFrame(hdr(12'h310, 2), 4, 4'hE, 0);
    check("R5", "trailer tag", {31'b0, fmtErr}, 32'd1);
    doReset();
    // R5: bad header tag
    pushRef(12'h320);
    sendFrame({4'b1101, hdr(12'h320, 0)[27:0]}, 2, 4'hF, 0);
    check("R5", "header tag", {31'b0, fmtErr}, 32'd1);
    doReset();

    // R9: single-word frame
    pushRef(12'h400);
    sendFrame(hdr(12'h400, 0), 1, 4'hF, 0);
    check("R9", "len flag", {31'b0, lenErr}, 32'd1);
    check("R9", "fmt flag", {31'b0, fmtErr}, 32'd1);
    doReset();
    @(negedge clk); #0 check("R1", "flags cleared by reset", {29'b0, lenErr, fmtErr, cmpErr}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule